// File: doc/BRIEF.md
# Auxiliary Event Timestamp Snapshot

This block records the system time at the moment an external event occurs. A free-running 64-bit time value comes in as an input. An asynchronous event pin is first brought into the system clock domain. On each rising edge of the resynchronised signal, the block copies the full time value into a snapshot held as two 32-bit words. The block always treats the event pin as an input, whatever direction the pad is given elsewhere.

A status bit records that a snapshot has been taken. While this bit is set, the snapshot is frozen and further events are dropped, so software can read both words without a race. Software re-arms the capture by writing a one to the status bit. Writing a zero to it does nothing. Reads go through a simple address/data port. The read data is combinational from the address. Writes take effect at the clock edge on which the write strobe is high.

Top module: `aux_snap_capture`

## Requirements
- R1: After reset, the snapshot low word, the snapshot high word and the snapshot-taken flag all read as zero.
- R2: The event input passes through two synchronising flip-flops and an edge detector. A rise of the event input that is set up before clock edge 1 causes a capture at clock edge 3, and the value captured is the time input present at that edge. Before edge 3 the flag stays zero.
- R3: All 64 bits are captured on the same edge. The low word at byte offset 0x038 and the high word at byte offset 0x03C form one consistent value, including when the time carries from the low word into the high word.
- R4: A capture sets the snapshot-taken flag. The flag is visible on `snap_flag_o` and as bit 0 of the status word at byte offset 0x020.
- R5: While the flag is set, event edges do not change the snapshot.
- R6: Writing a word with bit 0 set to offset 0x020 clears the flag. Writing a word with bit 0 clear to that offset leaves the flag unchanged.
- R7: If a clearing write and an event edge fall on the same clock edge, the flag ends cleared and the snapshot keeps its previous value.
- R8: Capture is triggered by an edge, not by a level. An event input held high after the flag is cleared causes no new capture.
- R9: Writes to offsets 0x038 and 0x03C do not change the snapshot.
- R10: Reads of any offset other than 0x020, 0x038 and 0x03C return zero. All bits of the status word other than bit 0 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_async_i | input | 1 | Asynchronous external event input |
| sys_time_i | input | 64 | Free-running system time value |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from address) |
| snap_flag_o | output | 1 | Snapshot-taken flag |

## Verification
Two of this block's functions can act on the same clock edge: the rising edge from the event synchroniser and a software clear of the snapshot-taken flag. The bench provokes this case directly. It raises the event pin and then places the status write so that it is sampled on the third edge after the rise, the same edge on which the detected rise is presented. It judges the outcome in three ways. The flag must read zero. The snapshot words must still hold the earlier capture. Because the pin stays high, no capture may follow on later cycles.

// File: rtl/asc_pkg.sv
package asc_pkg;
  localparam int unsigned OFS_STATUS  = 'h20;
  localparam int unsigned OFS_SNAP_LO = 'h38;
  localparam int unsigned OFS_SNAP_HI = 'h3C;
  localparam int unsigned FLAG_BIT    = 0;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_LO,
    SEL_HI
  } reg_sel_e;
endpackage

// File: rtl/asc_sync.sv
module asc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_o
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic stage_q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= 1'b0;
        else        stage_q <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= 1'b0;
        else        stage_q <= g_stage[g-1].stage_q;
      end
    end
  end

  assign q_o = g_stage[STAGES-1].stage_q;
endmodule

// File: rtl/asc_edge.sv
module asc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/asc_snap_regs.sv
module asc_snap_regs #(
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_i,
  input  logic              clr_i,
  input  logic [TIME_W-1:0] time_i,
  output logic [TIME_W-1:0] snap_o,
  output logic              flag_o
);
  logic              flag_q;
  logic [TIME_W-1:0] snap_q;
  logic              take;

  // a pending clear blocks capture on the same edge
  assign take = rise_i & ~flag_q & ~clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (clr_i) begin
      flag_q <= 1'b0;
    end else if (take) begin
      flag_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    snap_q <= '0;
    else if (take) snap_q <= time_i;
  end

  assign snap_o = snap_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/asc_regif.sv
module asc_regif
  import asc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [2*DATA_W-1:0] snap_i,
  input  logic                flag_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                clr_o
);
  reg_sel_e sel;
  logic     wdata_unused;

  always_comb begin
    if (addr_i == ADDR_W'(OFS_STATUS))       sel = SEL_STATUS;
    else if (addr_i == ADDR_W'(OFS_SNAP_LO)) sel = SEL_LO;
    else if (addr_i == ADDR_W'(OFS_SNAP_HI)) sel = SEL_HI;
    else                                     sel = SEL_NONE;
  end

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_STATUS: rdata_o[FLAG_BIT] = flag_i;
      SEL_LO:     rdata_o = snap_i[DATA_W-1:0];
      SEL_HI:     rdata_o = snap_i[2*DATA_W-1:DATA_W];
      default:    rdata_o = '0;
    endcase
  end

  assign clr_o        = wr_en_i && (sel == SEL_STATUS) && wdata_i[FLAG_BIT];
  assign wdata_unused = ^wdata_i;
endmodule

// File: rtl/aux_snap_capture.sv
module aux_snap_capture
  import asc_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evt_async_i,
  input  logic [2*DATA_W-1:0] sys_time_i,
  input  logic                reg_wr_en_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                snap_flag_o
);
  localparam int unsigned TIME_W = 2 * DATA_W;

  logic              evt_sync;
  logic              evt_rise;
  logic              sw_clr;
  logic [TIME_W-1:0] snap_q;
  logic              flag;

  asc_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (evt_async_i),
    .q_o     (evt_sync)
  );

  asc_edge edge_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (evt_sync),
    .rise_o (evt_rise)
  );

  asc_snap_regs #(.TIME_W(TIME_W)) snap_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise_i (evt_rise),
    .clr_i  (sw_clr),
    .time_i (sys_time_i),
    .snap_o (snap_q),
    .flag_o (flag)
  );

  asc_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regif_i (
    .addr_i  (reg_addr_i),
    .wr_en_i (reg_wr_en_i),
    .wdata_i (reg_wdata_i),
    .snap_i  (snap_q),
    .flag_i  (flag),
    .rdata_o (reg_rdata_o),
    .clr_o   (sw_clr)
  );

  assign snap_flag_o = flag;
endmodule

// File: rtl/asc_checker.sv
module asc_checker
  import asc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr_en_i,
  input logic [ADDR_W-1:0]   reg_addr_i,
  input logic [DATA_W-1:0]   reg_wdata_i,
  input logic [DATA_W-1:0]   reg_rdata_o,
  input logic                snap_flag_o,
  input logic [2*DATA_W-1:0] snap_q
);
  logic clr_w;
  logic mapped;
  logic wdata_unused;

  assign clr_w  = reg_wr_en_i && (reg_addr_i == ADDR_W'(OFS_STATUS)) && reg_wdata_i[FLAG_BIT];
  assign mapped = (reg_addr_i == ADDR_W'(OFS_STATUS)) || (reg_addr_i == ADDR_W'(OFS_SNAP_LO)) ||
                  (reg_addr_i == ADDR_W'(OFS_SNAP_HI));
  assign wdata_unused = ^reg_wdata_i;

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_ZERO: assert (snap_q == '0 && !snap_flag_o) else $error("reset state"); // R1
    end
  end

  AST_CAPTURE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(snap_q) |-> $rose(snap_flag_o)); // R4

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    snap_flag_o |=> $stable(snap_q)); // R5

  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_flag_o && !clr_w) |=> snap_flag_o); // R6

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> !snap_flag_o); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (reg_rdata_o == '0)); // R10
endmodule

bind aux_snap_capture asc_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en_i (reg_wr_en_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .snap_flag_o (snap_flag_o),
  .snap_q      (snap_q)
);

// File: tb/aux_snap_capture_tb_top.sv
module aux_snap_capture_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_ST = 8'h20;
  localparam logic [7:0] A_LO = 8'h38;
  localparam logic [7:0] A_HI = 8'h3C;

  typedef struct packed {
    logic [63:0] base;
    logic [63:0] expv;
  } vec_t;

  // expected = base + 2 (time advances twice between the rise and edge 3)
  localparam vec_t VECS [6] = '{
    '{64'h0000_0000_0000_0010, 64'h0000_0000_0000_0012},
    '{64'h0000_0001_FFFF_FFFE, 64'h0000_0002_0000_0000},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001},
    '{64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF2},
    '{64'h0000_0000_FFFF_FFFF, 64'h0000_0001_0000_0001},
    '{64'hA5A5_A5A5_5A5A_5A5A, 64'hA5A5_A5A5_5A5A_5A5C}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt = 1'b0;
  logic [63:0] tcnt = '0;
  logic        ld_en = 1'b0;
  logic [63:0] ld_val = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        flag;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) tcnt <= ld_en ? ld_val : tcnt + 64'd1;

  aux_snap_capture dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_async_i (evt),
    .sys_time_i  (tcnt),
    .reg_wr_en_i (wr_en),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .snap_flag_o (flag)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic rd64(output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(A_LO, lo);
    rd(A_HI, hi);
    v = {hi, lo};
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    summary();
  end

  initial begin
    logic [31:0] d;
    logic [63:0] v, held;

    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(A_LO, d); chk("R1 low word", d, 0);
    rd(A_HI, d); chk("R1 high word", d, 0);
    rd(A_ST, d); chk("R1 status", d, 0);
    chk("R1 flag pin", flag, 0);

    // table walk: R2 timing, R3 coherency, R4 flag, R6 clear
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_val = VECS[i].base;
      @(negedge clk);
      ld_en = 1'b0; evt = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      chk("R2 no capture before edge 3", flag, 0);
      @(posedge clk);
      @(negedge clk);
      chk("R4 flag pin set", flag, 1);
      rd(A_ST, d); chk("R4 status word", d, 1);
      rd64(v); chk("R3 coherent snapshot", v, VECS[i].expv);
      evt = 1'b0;
      wr(A_ST, 32'h1);
      chk("R6 clear by writing one", flag, 0);
      idle(4);
    end

    // capture a known value, then lock it
    @(negedge clk);
    ld_en = 1'b1; ld_val = 64'h0000_00AA_0000_0100;
    @(negedge clk);
    ld_en = 1'b0; evt = 1'b1;
    idle(4);
    rd64(held);
    chk("R2 capture value", held, 64'h0000_00AA_0000_0102);
    evt = 1'b0;
    idle(4);

    // R5 lockout
    evt = 1'b1;
    idle(6);
    rd64(v); chk("R5 snapshot locked", v, held);
    chk("R5 flag held", flag, 1);

    // R6 write zero has no effect
    wr(A_ST, 32'hFFFF_FFFE);
    chk("R6 write zero keeps flag", flag, 1);

    // R9 writes to snapshot words ignored
    wr(A_LO, 32'hDEAD_BEEF);
    wr(A_HI, 32'hCAFE_F00D);
    rd64(v); chk("R9 snapshot not writable", v, held);

    // R10 unmapped reads
    rd(8'h00, d); chk("R10 offset 0x00", d, 0);
    rd(8'h24, d); chk("R10 offset 0x24", d, 0);
    rd(8'h3A, d); chk("R10 offset 0x3A", d, 0);
    rd(A_ST, d);  chk("R10 status upper bits", d, 1);

    // R8 level held high after clear: no new capture
    wr(A_ST, 32'h1);
    idle(6);
    chk("R8 no retrigger on level", flag, 0);
    rd64(v); chk("R8 snapshot unchanged", v, held);

    // re-arm with a fresh capture for the collision test
    evt = 1'b0;
    idle(4);
    evt = 1'b1;
    idle(5);
    chk("R4 flag set again", flag, 1);
    rd64(held);
    evt = 1'b0;
    idle(4);

    // R7 clear and event edge on the same clock edge
    @(negedge clk);
    evt = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = A_ST; wdata = 32'h1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R7 clear wins", flag, 0);
    rd64(v); chk("R7 snapshot unchanged", v, held);
    idle(5);
    chk("R7 edge consumed", flag, 0);

    summary();
  end
endmodule